// File: doc/BRIEF.md
# Used Ring Completion and Interrupt Notifier

This block hands finished requests back to a software driver through a shared used ring in memory and decides whether the driver gets an interrupt. A completion command writes a two-word element, the request's head id and its byte count, into the used ring at the slot chosen by the device's private next-used counter. The counter then advances. The shared used index that the driver polls is written only when a sync command arrives. Several completions can therefore be batched behind one index update.

After publishing the index, a sync reads two words from the available ring: the driver's flags word and its available index. From these it decides whether to raise an interrupt. A raise sets the queue cause bit in an interrupt status register and holds a level interrupt line high. Reading that register through a strobe returns its value, clears it and drops the line. A separate pair of commands edits the no-notify bit in the used ring's flags word with a read-modify-write. Two event counters record how many interrupts were raised and how many were suppressed.

Top module: `used_ring_notifier`

## Requirements
- R1: A completion command (cmd_op 0) writes cmd_id to word address used_base+2+2*s and cmd_len to used_base+3+2*s, where s is the next-used counter modulo RING_SIZE. The id is written in the cycle before the length. The counter then increments by one and wraps at 2^IDX_W.
- R2: The used index word at used_base+1 is written only by a sync command (cmd_op 1). The value written is the next-used counter, zero-extended. A completion never writes that address.
- R3: After a sync, an interrupt is raised when bit 0 (no-interrupt) of the available flags word at avail_base+0 is clear.
- R4: After a sync, an interrupt is also raised when bit 0 is set, provided feat_notify_empty is high and the low IDX_W bits of the available index word at avail_base+1 equal next_avail_idx (queue empty).
- R5: A sync that raises nothing leaves isr_rdata and irq unchanged and increments skipped_cnt by one.
- R6: A raise ORs bit 0 into the status register, drives irq high and increments raised_cnt by one.
- R7: With isr_rd high, isr_rdata shows the current status value. After that edge the register is zero and irq is low. Without a read or a raise, irq and the status hold their values.
- R8: A raise in the same cycle as a status read leaves bit 0 set and irq high afterwards.
- R9: cmd_op 3 reads the used flags word at used_base+0 and writes it back with bit 0 (no-notify) set. cmd_op 2 does the same with bit 0 cleared. All other bits are written back unchanged.
- R10: cmd_ready is high only when idle. A command is accepted on a clock edge with cmd_valid and cmd_ready both high. While a command runs, cmd_ready stays low and no new command is taken.
- R11: After reset, cmd_ready is 1, irq is 0, isr_rdata is 0, both counters are 0, mem_req is 0, and the next-used counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| used_base | input | AW | Word address of the used ring |
| avail_base | input | AW | Word address of the available ring |
| feat_notify_empty | input | 1 | Notify-on-empty feature negotiated |
| next_avail_idx | input | IDX_W | Device's next available index, used for the empty test |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 complete, 1 sync, 2 enable notify, 3 disable notify |
| cmd_id | input | IDX_W | Head id for a completion |
| cmd_len | input | DW | Byte count for a completion |
| cmd_ready | output | 1 | Idle and able to accept a command |
| mem_req | output | 1 | Memory access request, always accepted |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| isr_rd | input | 1 | Status register read strobe |
| isr_rdata | output | ISR_W | Status register value |
| irq | output | 1 | Level interrupt |
| raised_cnt | output | CNT_W | Raised interrupts |
| skipped_cnt | output | CNT_W | Suppressed interrupts |

## Verification
A completion puts its id write on the memory port in the first cycle after acceptance and its length write in the second. A sync writes the used index one cycle after acceptance. The sync's raise or skip reaches the status register, the interrupt line and the counters six cycles after acceptance, which is the edge at which cmd_ready returns. The checks compare every memory write against an expected stream in the cycle it appears. They compare interrupt state with the model only once the command has returned to idle. A status read is checked in the strobe cycle and again one cycle later. The same-cycle collision is built by counting two cycles past the available-index read, so the read strobe lands exactly on the decision edge.

// File: rtl/ur_pkg.sv
package ur_pkg;
  typedef enum logic [1:0] {
    OP_DONE      = 2'd0,
    OP_SYNC      = 2'd1,
    OP_NOTIF_ON  = 2'd2,
    OP_NOTIF_OFF = 2'd3
  } ur_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_W_ID, S_W_LEN, S_W_UIDX, S_R_AFLG, S_WT_AFLG,
    S_R_AIDX, S_WT_AIDX, S_DECIDE, S_R_UFLG, S_WT_UFLG, S_W_UFLG
  } ur_state_e;

  // word offsets inside the rings
  localparam int UOFF_FLAGS = 0;
  localparam int UOFF_IDX   = 1;
  localparam int UOFF_ELEM  = 2;
  localparam int ELEM_WORDS = 2;
  localparam int AOFF_FLAGS = 0;
  localparam int AOFF_IDX   = 1;

  // bit positions
  localparam int CAUSE_QUEUE_BIT    = 0;
  localparam int AVAIL_NO_IRQ_BIT   = 0;
  localparam int USED_NO_NOTIFY_BIT = 0;
endpackage

// File: rtl/ur_ring_ptr.sv
module ur_ring_ptr #(
  parameter int IDX_W     = 16,
  parameter int RING_SIZE = 8,
  parameter int SLOT_W    = (RING_SIZE > 1) ? $clog2(RING_SIZE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [IDX_W-1:0]  next_used,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [IDX_W-1:0] RING_LIM = IDX_W'(RING_SIZE);

  logic [IDX_W-1:0] nu_q;
  logic [IDX_W-1:0] nu_d;

  always_comb begin
    nu_d = nu_q;
    if (adv) nu_d = nu_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   nu_q <= '0;
    else if (adv) nu_q <= nu_d;
  end

  logic [IDX_W-1:0] slot_full;
  assign slot_full = nu_q % RING_LIM;
  assign slot      = slot_full[SLOT_W-1:0];
  assign next_used = nu_q;
endmodule

// File: rtl/ur_evt_cnt.sv
module ur_evt_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb cnt_d = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ur_isr.sv
module ur_isr
  import ur_pkg::*;
#(
  parameter int ISR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raise,
  input  logic             rd,
  output logic [ISR_W-1:0] isr,
  output logic             irq
);
  localparam logic [ISR_W-1:0] CAUSE_MASK = ISR_W'(1) << CAUSE_QUEUE_BIT;

  logic [ISR_W-1:0] isr_q, isr_d;
  logic             irq_q, irq_d;
  logic             upd;

  always_comb begin
    isr_d = isr_q;
    irq_d = irq_q;
    if (rd) begin
      isr_d = '0;
      irq_d = 1'b0;
    end
    if (raise) begin
      // a raise wins over a read in the same cycle
      isr_d = isr_d | CAUSE_MASK;
      irq_d = 1'b1;
    end
  end

  assign upd = raise | rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      irq_q <= 1'b0;
    end else if (upd) begin
      isr_q <= isr_d;
      irq_q <= irq_d;
    end
  end

  assign isr = isr_q;
  assign irq = irq_q;
endmodule

// File: rtl/ur_seq.sv
module ur_seq
  import ur_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int IDX_W  = 16,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     used_base,
  input  logic [AW-1:0]     avail_base,
  input  logic              feat_notify_empty,
  input  logic [IDX_W-1:0]  next_avail_idx,
  input  logic              cmd_valid,
  input  ur_op_e            cmd_op,
  input  logic [IDX_W-1:0]  cmd_id,
  input  logic [DW-1:0]     cmd_len,
  output logic              cmd_ready,
  input  logic [IDX_W-1:0]  next_used,
  input  logic [SLOT_W-1:0] slot,
  output logic              adv,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DW-1:0]     mem_rdata,
  output logic              raise,
  output logic              skip
);
  localparam logic [DW-1:0] NN_MASK  = DW'(1) << USED_NO_NOTIFY_BIT;
  localparam logic [AW-1:0] A_UFLG   = AW'(UOFF_FLAGS);
  localparam logic [AW-1:0] A_UIDX   = AW'(UOFF_IDX);
  localparam logic [AW-1:0] A_UELEM  = AW'(UOFF_ELEM);
  localparam logic [AW-1:0] A_EWORDS = AW'(ELEM_WORDS);
  localparam logic [AW-1:0] A_AFLG   = AW'(AOFF_FLAGS);
  localparam logic [AW-1:0] A_AIDX   = AW'(AOFF_IDX);

  ur_state_e        state_q, state_d;
  ur_op_e           op_q;
  logic [IDX_W-1:0] id_q;
  logic [DW-1:0]    len_q;
  logic [DW-1:0]    flg_q;
  logic [IDX_W-1:0] aidx_q;
  logic             load_cmd, cap_flg, cap_idx;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    load_cmd = 1'b0;
    cap_flg  = 1'b0;
    cap_idx  = 1'b0;
    adv      = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (cmd_valid) begin
          load_cmd = 1'b1;
          case (cmd_op)
            OP_DONE: state_d = S_W_ID;
            OP_SYNC: state_d = S_W_UIDX;
            default: state_d = S_R_UFLG;
          endcase
        end
      end
      S_W_ID:   state_d = S_W_LEN;
      S_W_LEN: begin
        adv     = 1'b1;
        state_d = S_IDLE;
      end
      S_W_UIDX: state_d = S_R_AFLG;
      S_R_AFLG: state_d = S_WT_AFLG;
      S_WT_AFLG: begin
        if (mem_rvalid) begin
          cap_flg = 1'b1;
          state_d = S_R_AIDX;
        end
      end
      S_R_AIDX: state_d = S_WT_AIDX;
      S_WT_AIDX: begin
        if (mem_rvalid) begin
          cap_idx = 1'b1;
          state_d = S_DECIDE;
        end
      end
      S_DECIDE: state_d = S_IDLE;
      S_R_UFLG: state_d = S_WT_UFLG;
      S_WT_UFLG: begin
        if (mem_rvalid) begin
          cap_flg = 1'b1;
          state_d = S_W_UFLG;
        end
      end
      S_W_UFLG: state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_DONE;
      id_q  <= '0;
      len_q <= '0;
    end else if (load_cmd) begin
      op_q  <= cmd_op;
      id_q  <= cmd_id;
      len_q <= cmd_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flg_q <= '0;
    else if (cap_flg) flg_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       aidx_q <= '0;
    else if (cap_idx) aidx_q <= mem_rdata[IDX_W-1:0];
  end

  // memory port
  logic [AW-1:0] elem_addr;
  assign elem_addr = used_base + A_UELEM + AW'(slot) * A_EWORDS;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state_q)
      S_W_ID: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = elem_addr;
        mem_wdata = DW'(id_q);
      end
      S_W_LEN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = elem_addr + 1'b1;
        mem_wdata = len_q;
      end
      S_W_UIDX: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = used_base + A_UIDX;
        mem_wdata = DW'(next_used);
      end
      S_R_AFLG: begin
        mem_req  = 1'b1;
        mem_addr = avail_base + A_AFLG;
      end
      S_R_AIDX: begin
        mem_req  = 1'b1;
        mem_addr = avail_base + A_AIDX;
      end
      S_R_UFLG: begin
        mem_req  = 1'b1;
        mem_addr = used_base + A_UFLG;
      end
      S_W_UFLG: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = used_base + A_UFLG;
        mem_wdata = (op_q == OP_NOTIF_OFF) ? (flg_q | NN_MASK) : (flg_q & ~NN_MASK);
      end
      default: ;
    endcase
  end

  // interrupt decision
  logic suppressed, q_empty, want;
  assign suppressed = flg_q[AVAIL_NO_IRQ_BIT];
  assign q_empty    = (aidx_q == next_avail_idx);
  assign want       = !suppressed || (feat_notify_empty && q_empty);
  assign raise      = (state_q == S_DECIDE) && want;
  assign skip       = (state_q == S_DECIDE) && !want;
  assign cmd_ready  = (state_q == S_IDLE);
endmodule

// File: rtl/used_ring_notifier.sv
module used_ring_notifier
  import ur_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int IDX_W     = 16,
  parameter int RING_SIZE = 8,
  parameter int CNT_W     = 16,
  parameter int ISR_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    used_base,
  input  logic [AW-1:0]    avail_base,
  input  logic             feat_notify_empty,
  input  logic [IDX_W-1:0] next_avail_idx,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_id,
  input  logic [DW-1:0]    cmd_len,
  output logic             cmd_ready,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             isr_rd,
  output logic [ISR_W-1:0] isr_rdata,
  output logic             irq,
  output logic [CNT_W-1:0] raised_cnt,
  output logic [CNT_W-1:0] skipped_cnt
);
  localparam int SLOT_W = (RING_SIZE > 1) ? $clog2(RING_SIZE) : 1;
  localparam int N_EVT  = 2;

  ur_op_e            op_in;
  logic              adv;
  logic [IDX_W-1:0]  next_used;
  logic [SLOT_W-1:0] slot;
  logic              raise, skip;
  logic [N_EVT-1:0]  evt;
  logic [CNT_W-1:0]  evt_cnt [N_EVT];

  assign op_in = ur_op_e'(cmd_op);

  ur_ring_ptr #(.IDX_W(IDX_W), .RING_SIZE(RING_SIZE), .SLOT_W(SLOT_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(adv), .next_used(next_used), .slot(slot)
  );

  ur_seq #(.AW(AW), .DW(DW), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .used_base(used_base), .avail_base(avail_base),
    .feat_notify_empty(feat_notify_empty), .next_avail_idx(next_avail_idx),
    .cmd_valid(cmd_valid), .cmd_op(op_in), .cmd_id(cmd_id), .cmd_len(cmd_len),
    .cmd_ready(cmd_ready),
    .next_used(next_used), .slot(slot), .adv(adv),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .raise(raise), .skip(skip)
  );

  ur_isr #(.ISR_W(ISR_W)) u_isr (
    .clk(clk), .rst_n(rst_n), .raise(raise), .rd(isr_rd),
    .isr(isr_rdata), .irq(irq)
  );

  // event 0: raised, event 1: skipped
  assign evt = {skip, raise};

  for (genvar g = 0; g < N_EVT; g++) begin : g_cnt
    ur_evt_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(evt[g]), .cnt(evt_cnt[g])
    );
  end

  assign raised_cnt  = evt_cnt[0];
  assign skipped_cnt = evt_cnt[1];
endmodule

// File: rtl/ur_chk.sv
module ur_chk #(
  parameter int CNT_W = 16,
  parameter int ISR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             raise,
  input logic             skip,
  input logic             isr_rd,
  input logic [ISR_W-1:0] isr_rdata,
  input logic             irq,
  input logic [CNT_W-1:0] raised_cnt,
  input logic [CNT_W-1:0] skipped_cnt,
  input logic             mem_req,
  input logic             cmd_ready
);
  AST_RAISE_SETS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    raise |=> (isr_rdata[0] && irq)); // R6

  AST_RAISE_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (raise && isr_rd) |=> (isr_rdata[0] && irq)); // R8

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && !raise) |=> (isr_rdata == '0 && !irq)); // R7

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !isr_rd) |=> irq); // R7

  AST_NO_SPURIOUS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !raise) |=> !irq); // R5

  AST_RAISED_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    raise |=> raised_cnt == CNT_W'($past(raised_cnt) + 1'b1)); // R6

  AST_SKIPPED_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    skip |=> skipped_cnt == CNT_W'($past(skipped_cnt) + 1'b1)); // R5

  AST_RAISE_SKIP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(raise && skip)); // R5

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cmd_ready); // R10
endmodule

bind used_ring_notifier ur_chk #(.CNT_W(CNT_W), .ISR_W(ISR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .raise(raise), .skip(skip), .isr_rd(isr_rd),
  .isr_rdata(isr_rdata), .irq(irq), .raised_cnt(raised_cnt),
  .skipped_cnt(skipped_cnt), .mem_req(mem_req), .cmd_ready(cmd_ready)
);

// File: tb/used_ring_notifier_tb.sv
module used_ring_notifier_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, DW = 32, IDX_W = 16, RING = 8, CNT_W = 16, ISR_W = 8;
  localparam logic [AW-1:0] UB = 16'h0100;
  localparam logic [AW-1:0] AB = 16'h0040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic feat = 1'b0;
  logic [IDX_W-1:0] next_avail = '0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [IDX_W-1:0] cmd_id = '0;
  logic [DW-1:0] cmd_len = '0;
  logic cmd_ready, mem_req, mem_we, irq;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic isr_rd = 1'b0;
  logic [ISR_W-1:0] isr_rdata;
  logic [CNT_W-1:0] raised_cnt, skipped_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  used_ring_notifier #(.AW(AW), .DW(DW), .IDX_W(IDX_W), .RING_SIZE(RING),
                       .CNT_W(CNT_W), .ISR_W(ISR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .used_base(UB), .avail_base(AB),
    .feat_notify_empty(feat), .next_avail_idx(next_avail),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_id(cmd_id), .cmd_len(cmd_len),
    .cmd_ready(cmd_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .isr_rd(isr_rd), .isr_rdata(isr_rdata), .irq(irq),
    .raised_cnt(raised_cnt), .skipped_cnt(skipped_cnt)
  );

  // behavioural memory, read data one cycle later
  logic [DW-1:0] mem [int];

  function automatic logic [DW-1:0] rd(input logic [AW-1:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : '0;
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= mem_req && !mem_we;
    if (mem_req && mem_we) mem[int'(mem_addr)] = mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= rd(mem_addr);
  end

  // reference model state
  int checks = 0, errors = 0;
  int ref_nu = 0, ref_raised = 0, ref_skipped = 0;
  logic [ISR_W-1:0] ref_isr = '0;
  logic ref_irq = 1'b0;
  bit mdl_on = 1'b0;
  logic [AW+DW-1:0] exp_q[$];
  string exp_tag[$];

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic push_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    exp_q.push_back({a, d});
    exp_tag.push_back(tag);
  endtask

  // per-clock comparison: write stream always, interrupt state when idle
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_we) begin
      if (exp_q.size() == 0) begin
        chk("R2", "unexpected write", {mem_addr, mem_wdata}, 64'hDEAD);
      end else begin
        logic [AW+DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        chk(t, "memory write", {mem_addr, mem_wdata}, e);
      end
    end
    if (rst_n && mdl_on) begin
      chk("R7", "irq model", irq, ref_irq);
      chk("R7", "isr model", isr_rdata, ref_isr);
      chk("R6", "raised model", raised_cnt, ref_raised);
      chk("R5", "skipped model", skipped_cnt, ref_skipped);
    end
  end

  task automatic do_cmd(input logic [1:0] op, input logic [IDX_W-1:0] id, input logic [DW-1:0] len);
    @(negedge clk);
    cmd_op = op; cmd_id = id; cmd_len = len; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10", "cmd_ready low while busy", cmd_ready, 0);
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic complete(input logic [IDX_W-1:0] id, input logic [DW-1:0] len);
    logic [AW-1:0] ea;
    ea = UB + AW'(2) + AW'(2 * (ref_nu % RING));
    push_wr(ea, DW'(id), "R1");
    push_wr(ea + 1'b1, len, "R1");
    do_cmd(2'd0, id, len);
    ref_nu = (ref_nu + 1) % 65536;
  endtask

  function automatic bit exp_raise();
    logic [DW-1:0] fl, ai;
    fl = rd(AB);
    ai = rd(AB + 1'b1);
    return !fl[0] || (feat && ai[IDX_W-1:0] == next_avail);
  endfunction

  task automatic apply_decision(input bit rz);
    if (rz) begin
      ref_isr = ref_isr | 8'h01;
      ref_irq = 1'b1;
      ref_raised++;
    end else begin
      ref_skipped++;
    end
  endtask

  task automatic do_sync(input string tag);
    bit rz;
    rz = exp_raise();
    push_wr(UB + 1'b1, DW'(ref_nu), "R2");
    mdl_on = 1'b0;
    do_cmd(2'd1, '0, '0);
    apply_decision(rz);
    chk(tag, "irq after sync", irq, ref_irq);
    chk(tag, "isr after sync", isr_rdata, ref_isr);
    chk(tag, "raised_cnt", raised_cnt, ref_raised);
    chk(tag, "skipped_cnt", skipped_cnt, ref_skipped);
    mdl_on = 1'b1;
  endtask

  task automatic read_isr();
    mdl_on = 1'b0;
    @(negedge clk);
    isr_rd = 1'b1;
    #1 chk("R7", "isr read value", isr_rdata, ref_isr);
    @(negedge clk);
    isr_rd = 1'b0;
    ref_isr = '0;
    ref_irq = 1'b0;
    chk("R7", "irq after read", irq, 0);
    chk("R7", "isr after read", isr_rdata, 0);
    mdl_on = 1'b1;
  endtask

  // sync whose decision edge coincides with a status read
  task automatic sync_with_read();
    bit rz;
    logic [ISR_W-1:0] pre;
    rz = exp_raise();
    pre = ref_isr;
    push_wr(UB + 1'b1, DW'(ref_nu), "R2");
    mdl_on = 1'b0;
    fork
      do_cmd(2'd1, '0, '0);
      begin
        do @(negedge clk); while (!(mem_req && !mem_we && mem_addr == AB + 1'b1));
        @(negedge clk);
        @(negedge clk);
        isr_rd = 1'b1;
        #1 chk("R8", "isr value on collision read", isr_rdata, pre);
        @(negedge clk);
        isr_rd = 1'b0;
      end
    join
    ref_isr = '0;
    ref_irq = 1'b0;
    apply_decision(rz);
    chk("R8", "cause kept after collision", isr_rdata, 8'h01);
    chk("R8", "irq kept after collision", irq, 1);
    mdl_on = 1'b1;
  endtask

  task automatic notif(input bit disable_n);
    logic [DW-1:0] v;
    v = rd(UB);
    v[0] = disable_n;
    push_wr(UB, v, "R9");
    do_cmd(disable_n ? 2'd3 : 2'd2, '0, '0);
    chk("R9", "used flags in memory", rd(UB), v);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    chk("R11", "cmd_ready", cmd_ready, 1);
    chk("R11", "irq", irq, 0);
    chk("R11", "isr", isr_rdata, 0);
    chk("R11", "raised_cnt", raised_cnt, 0);
    chk("R11", "skipped_cnt", skipped_cnt, 0);
    chk("R11", "mem_req", mem_req, 0);
    @(negedge clk);
    rst_n = 1'b1;
    mdl_on = 1'b1;

    // R1 first completion lands at slot 0, proving the counter starts at 0 (R11)
    mem[int'(AB)] = 32'h0; mem[int'(AB + 1)] = 32'd5; next_avail = 16'd3;
    complete(16'h0011, 32'd100);
    complete(16'h0022, 32'd200);
    complete(16'h0033, 32'd300);
    do_sync("R3");                       // flags clear -> raise
    read_isr();                          // R7

    mem[int'(AB)] = 32'h1;               // suppressed, feature off
    do_sync("R5");
    feat = 1'b1; next_avail = 16'd5;     // R4 empty with feature
    do_sync("R4");
    read_isr();
    next_avail = 16'd4;                  // feature on but not empty
    do_sync("R5");
    feat = 1'b0; next_avail = 16'd5;     // empty but feature off
    do_sync("R5");

    // R1 wrap of the slot
    for (int i = 0; i < 7; i++) complete(16'(16'h0100 + i), 32'(1000 + i));
    mem[int'(AB)] = 32'h0;
    do_sync("R3");
    do_sync("R6");                       // second raise while set
    do_sync("R2");                       // no completions, same index
    sync_with_read();                    // R8 with cause already set
    read_isr();
    sync_with_read();                    // R8 with cause clear
    read_isr();

    // R9 notification control
    mem[int'(UB)] = 32'h0000_00F0;
    notif(1'b1);
    notif(1'b0);
    mem[int'(UB)] = 32'hFFFF_FFFF;
    notif(1'b0);
    notif(1'b1);

    repeat (4) @(negedge clk);
    chk("R2", "all expected writes seen", exp_q.size(), 0);
    finish_run();
  end
endmodule